// File: doc/BRIEF.md
# Serial Whitening and CRC Bit Processor

This block processes a serial bit stream at one bit per clock whenever the input strobe is high. Two pseudo-noise generators, a 7-stage and a 9-stage one, each have their own enable. The sequence they produce is XORed onto the data, so one path both whitens outgoing data and de-whitens incoming data. A disabled generator adds nothing, and with both enabled the data carries the XOR of the two sequences.

Alongside the whitening, a CRC register with a run-time polynomial covers the plain data: the data before whitening when sending, and the data after de-whitening when receiving. The CRC width can be 8, 16, 24 or 32 bits. When sending, the block appends the CRC after the last data bit. When receiving, it checks that the remainder over data plus received CRC is zero and raises an error flag if it is not. A host-driven helper mode uses the same datapath to produce whitened sequences and CRCs. In that mode the appended CRC comes out unwhitened, so it can be read directly.

Control is a four-state machine. ST_IDLE waits for a frame. ST_DATA takes data bits. ST_APPEND shifts the CRC out. ST_CHECK evaluates the receive remainder for one cycle. The transitions are:
- START: frame_start, from any state to ST_DATA.
- END_TX: frame_end in ST_DATA while sending or in helper mode, to ST_APPEND.
- END_RX: frame_end in ST_DATA while receiving, to ST_CHECK.
- LAST_BIT: the final CRC bit in ST_APPEND, to ST_IDLE.
- DONE: from ST_CHECK to ST_IDLE.

Top module: `bitstream_proc`

## Requirements
- R1: After reset, out_valid, out_crc_phase and crc_error are 0, the machine is in ST_IDLE, and no output appears until a frame is started.
- R2: A bit accepted in ST_DATA (in_valid high, with frame_start and frame_end low) appears on out_bit with out_valid high exactly one clock later. Its value is in_bit XOR the whitening bit, so with both generators disabled, out_bit equals in_bit.
- R3: The 7-stage generator loads all ones at frame_start. Its output bit is the feedback bit w[6] XOR w[3], for the polynomial x^7+x^4+1. It shifts left, taking that feedback into bit 0, only on an accepted data bit or an appended CRC bit, so idle gaps inside a frame do not advance it.
- R4: The 9-stage generator loads all ones at frame_start. Its output and feedback bit is w[8] XOR w[4], for the polynomial x^9+x^5+1. It advances under the same rule as in R3.
- R5: A disabled generator contributes 0. With both enabled, the whitening bit is the XOR of the two output bits.
- R6: While sending (cfg_tx=1), the CRC register loads cfg_crc_seed at frame_start and processes each plain data bit MSB-first. The feedback is crc[W-1] XOR data, and when it is 1 the register is XORed with cfg_crc_poly, whose bit i is the coefficient of x^i below the implied top term. After frame_end, the W CRC bits are sent MSB first, whitened, one per clock, with out_crc_phase high.
- R7: While receiving (cfg_tx=0, cfg_copro=0), the CRC covers the de-whitened bits, including the received CRC, and nothing is appended. crc_error is set to 1 one clock after the ST_CHECK cycle if the W-bit remainder is non-zero, otherwise it is set to 0. It holds that value and is cleared by frame_start.
- R8: With cfg_copro=1, the block behaves as when sending, whatever the value of cfg_tx, except that the appended CRC bits are output without whitening.
- R9: in_valid is ignored outside ST_DATA: it produces no out_valid and does not advance any generator.
- R10: cfg_crc_len selects W as follows: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32. Exactly W bits are appended, and only the low W bits of the polynomial and the seed take part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pn7_en | input | 1 | Enable for the 7-stage whitening generator |
| cfg_pn9_en | input | 1 | Enable for the 9-stage whitening generator |
| cfg_tx | input | 1 | 1 = send (append CRC), 0 = receive (check CRC) |
| cfg_copro | input | 1 | Host helper mode: append CRC unwhitened |
| cfg_crc_len | input | 2 | CRC width code (8/16/24/32) |
| cfg_crc_poly | input | CRC_MAX_W | CRC polynomial without the top term |
| cfg_crc_seed | input | CRC_MAX_W | CRC start value |
| frame_start | input | 1 | Starts a frame; must come alone on its cycle |
| frame_end | input | 1 | Ends the data part of a frame |
| in_valid | input | 1 | Data bit strobe |
| in_bit | input | 1 | Data bit |
| out_valid | output | 1 | Output bit strobe |
| out_bit | output | 1 | Processed bit |
| out_crc_phase | output | 1 | High while appended CRC bits are output |
| crc_error | output | 1 | Receive CRC mismatch flag |

## Verification
The datapath is driven with several combinations of generator enables: none, the 7-stage only, the 9-stage only, and both. This tells a wrong tap or a wrong combination of the two sequences apart from a plain pass-through. Each combination is paired with a different CRC width and polynomial, which exposes errors in width masking, MSB selection and append length. Idle gaps are inserted inside frames to separate advance-on-accepted-bit from advance-every-clock. Receive frames built from a sent frame, one clean and one with a single flipped bit, distinguish correct remainder checking from a stuck flag. A helper-mode frame with cfg_tx low shows both that direction is ignored and that the append is unwhitened.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_APPEND,
        ST_CHECK
    } bsp_state_t;

    localparam int PN7_LEN = 7;
    localparam int PN7_TAP = 4;
    localparam int PN9_LEN = 9;
    localparam int PN9_TAP = 5;

endpackage

// File: rtl/bsp_pn_gen.sv
module bsp_pn_gen #(
    parameter int LEN = 7,
    parameter int TAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    input  logic en,
    output logic pn_bit
);

    logic [LEN-1:0] sr_q;
    logic           fb;

    assign fb     = sr_q[LEN-1] ^ sr_q[TAP-1];
    assign pn_bit = en & fb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '1;
        end else if (load) begin
            sr_q <= '1;
        end else if (step) begin
            sr_q <= {sr_q[LEN-2:0], fb};
        end
    end

endmodule

// File: rtl/bsp_crc_reg.sv
module bsp_crc_reg #(
    parameter int MAXW = 32,
    localparam int CW  = $clog2(MAXW) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MAXW-1:0] seed,
    input  logic            upd,
    input  logic            shift,
    input  logic            din,
    input  logic [MAXW-1:0] poly,
    input  logic [CW-1:0]   width,
    output logic            msb,
    output logic            is_zero
);

    localparam int IW = $clog2(MAXW);

    logic [MAXW-1:0] crc_q;
    logic [MAXW-1:0] crc_d;
    logic [MAXW-1:0] mask;
    logic [IW-1:0]   top_idx;
    logic            fb;

    always_comb begin
        for (int i = 0; i < MAXW; i++) begin
            mask[i] = (CW'(i) < width);
        end
    end

    assign top_idx = IW'(width - CW'(1));
    assign msb     = crc_q[top_idx];
    assign fb      = msb ^ din;
    assign is_zero = ((crc_q & mask) == '0);

    always_comb begin
        crc_d = crc_q;
        if (load) begin
            crc_d = seed & mask;
        end else if (upd) begin
            crc_d = ((crc_q << 1) ^ (fb ? poly : '0)) & mask;
        end else if (shift) begin
            crc_d = (crc_q << 1) & mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_d;
        end
    end

endmodule

// File: rtl/bsp_seq.sv
module bsp_seq
    import bsp_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          frame_end,
    input  logic          in_valid,
    input  logic          do_append,
    input  logic [CW-1:0] width,
    output bsp_state_t    st,
    output logic          data_step,
    output logic          app_step,
    output logic          chk_step
);

    bsp_state_t    st_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // next state
    always_comb begin
        st_d  = st;
        cnt_d = cnt_q;
        if (frame_start) begin
            st_d = ST_DATA;
        end else begin
            unique case (st)
                ST_IDLE: st_d = ST_IDLE;
                ST_DATA: begin
                    if (frame_end) begin
                        if (do_append) begin
                            st_d  = ST_APPEND;
                            cnt_d = width;
                        end else begin
                            st_d = ST_CHECK;
                        end
                    end
                end
                ST_APPEND: begin
                    cnt_d = cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) begin
                        st_d = ST_IDLE;
                    end
                end
                ST_CHECK: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st    <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        data_step = 1'b0;
        app_step  = 1'b0;
        chk_step  = 1'b0;
        unique case (st)
            ST_IDLE:   ;
            ST_DATA:   data_step = in_valid & ~frame_start & ~frame_end;
            ST_APPEND: app_step  = ~frame_start;
            ST_CHECK:  chk_step  = ~frame_start;
        endcase
    end

endmodule

// File: rtl/bitstream_proc.sv
module bitstream_proc
    import bsp_pkg::*;
#(
    parameter int CRC_MAX_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_pn7_en,
    input  logic                 cfg_pn9_en,
    input  logic                 cfg_tx,
    input  logic                 cfg_copro,
    input  logic [1:0]           cfg_crc_len,
    input  logic [CRC_MAX_W-1:0] cfg_crc_poly,
    input  logic [CRC_MAX_W-1:0] cfg_crc_seed,
    input  logic                 frame_start,
    input  logic                 frame_end,
    input  logic                 in_valid,
    input  logic                 in_bit,
    output logic                 out_valid,
    output logic                 out_bit,
    output logic                 out_crc_phase,
    output logic                 crc_error
);

    localparam int CW = $clog2(CRC_MAX_W) + 1;

    bsp_state_t    st;
    logic          data_step;
    logic          app_step;
    logic          chk_step;
    logic          pn7_bit;
    logic          pn9_bit;
    logic          wbit;
    logic          crc_msb;
    logic          crc_zero;
    logic          crc_din;
    logic          send_like;
    logic [CW-1:0] crc_w;

    assign crc_w     = CW'((32'(cfg_crc_len) + 32'd1) * 32'd8);
    assign send_like = cfg_tx | cfg_copro;
    assign wbit      = pn7_bit ^ pn9_bit;
    assign crc_din   = send_like ? in_bit : (in_bit ^ wbit);

    bsp_seq #(.CW(CW)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .in_valid    (in_valid),
        .do_append   (send_like),
        .width       (crc_w),
        .st          (st),
        .data_step   (data_step),
        .app_step    (app_step),
        .chk_step    (chk_step)
    );

    bsp_pn_gen #(.LEN(PN7_LEN), .TAP(PN7_TAP)) i_pn7 (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (frame_start),
        .step   (data_step | app_step),
        .en     (cfg_pn7_en),
        .pn_bit (pn7_bit)
    );

    bsp_pn_gen #(.LEN(PN9_LEN), .TAP(PN9_TAP)) i_pn9 (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (frame_start),
        .step   (data_step | app_step),
        .en     (cfg_pn9_en),
        .pn_bit (pn9_bit)
    );

    bsp_crc_reg #(.MAXW(CRC_MAX_W)) i_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (frame_start),
        .seed    (cfg_crc_seed),
        .upd     (data_step),
        .shift   (app_step),
        .din     (crc_din),
        .poly    (cfg_crc_poly),
        .width   (crc_w),
        .msb     (crc_msb),
        .is_zero (crc_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_bit       <= 1'b0;
            out_crc_phase <= 1'b0;
            crc_error     <= 1'b0;
        end else begin
            out_valid     <= data_step | app_step;
            out_crc_phase <= app_step;
            if (data_step) begin
                out_bit <= in_bit ^ wbit;
            end else if (app_step) begin
                out_bit <= cfg_copro ? crc_msb : (crc_msb ^ wbit);
            end
            if (frame_start) begin
                crc_error <= 1'b0;
            end else if (chk_step) begin
                crc_error <= ~crc_zero;
            end
        end
    end

endmodule

// File: rtl/bitstream_proc_chk.sv
module bitstream_proc_chk
    import bsp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_pn7_en,
    input logic       cfg_pn9_en,
    input logic [1:0] cfg_crc_len,
    input logic       frame_start,
    input logic       frame_end,
    input logic       in_valid,
    input logic       in_bit,
    input logic       out_valid,
    input logic       out_bit,
    input logic       out_crc_phase,
    input logic       crc_error,
    input bsp_state_t st
);

    logic [5:0] app_cnt;
    logic       abort_q;
    logic [5:0] exp_w;
    logic       accept;

    assign exp_w  = 6'((32'(cfg_crc_len) + 32'd1) * 32'd8);
    assign accept = (st == ST_DATA) && in_valid && !frame_start && !frame_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            app_cnt <= '0;
            abort_q <= 1'b0;
        end else begin
            app_cnt <= out_crc_phase ? app_cnt + 6'd1 : 6'd0;
            abort_q <= frame_start && (st == ST_APPEND);
        end
    end

    AST_PHASE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_crc_phase |-> out_valid); // R6

    AST_DATA_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_valid && !out_crc_phase)); // R2

    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cfg_pn7_en && !cfg_pn9_en) |=> (out_bit == $past(in_bit))); // R2

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !frame_start) |=> !out_valid); // R9

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !crc_error); // R7

    AST_APPEND_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_crc_phase) && !abort_q) |-> (app_cnt == exp_w)); // R10

endmodule

bind bitstream_proc bitstream_proc_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_pn7_en    (cfg_pn7_en),
    .cfg_pn9_en    (cfg_pn9_en),
    .cfg_crc_len   (cfg_crc_len),
    .frame_start   (frame_start),
    .frame_end     (frame_end),
    .in_valid      (in_valid),
    .in_bit        (in_bit),
    .out_valid     (out_valid),
    .out_bit       (out_bit),
    .out_crc_phase (out_crc_phase),
    .crc_error     (crc_error),
    .st            (st)
);

// File: tb/test_bitstream_proc.sv
`timescale 1ns/1ps
module test_bitstream_proc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pn7_en = 1'b0, cfg_pn9_en = 1'b0, cfg_tx = 1'b1, cfg_copro = 1'b0;
    logic [1:0]  cfg_crc_len = 2'd0;
    logic [31:0] cfg_crc_poly = '0, cfg_crc_seed = '0;
    logic        frame_start = 1'b0, frame_end = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
    logic        out_valid, out_bit, out_crc_phase, crc_error;

    always #2 clk = ~clk;

    bitstream_proc i_bitstream_proc (.*);

    int n_cmp = 0;
    int n_bad = 0;

    logic cap_b [0:127];
    logic cap_p [0:127];
    int   cap_n = 0;
    logic exp_b [0:127];
    logic exp_p [0:127];
    logic raw   [0:127];
    logic drv   [0:127];
    int   exp_n, drv_n;
    logic dat   [0:63];
    int   dat_n;

    logic [6:0]  m7;
    logic [8:0]  m9;
    logic [31:0] mc;

    always @(negedge clk) begin
        if (out_valid && cap_n < 128) begin
            cap_b[cap_n] = out_bit;
            cap_p[cap_n] = out_crc_phase;
            cap_n++;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic int wid();
        return (int'(cfg_crc_len) + 1) * 8;
    endfunction

    function automatic logic [31:0] wmask();
        return (wid() == 32) ? 32'hFFFF_FFFF : ((32'h1 << wid()) - 32'h1);
    endfunction

    // Whitening bit per R3/R4/R5, then advance both generators
    task automatic m_white(output logic w);
        logic f7, f9;
        f7 = m7[6] ^ m7[3];
        f9 = m9[8] ^ m9[4];
        w  = (cfg_pn7_en & f7) ^ (cfg_pn9_en & f9);
        m7 = {m7[5:0], f7};
        m9 = {m9[7:0], f9};
    endtask

    task automatic m_crc(input logic d);
        logic fb;
        fb = mc[wid()-1] ^ d;
        mc = ((mc << 1) ^ (fb ? cfg_crc_poly : 32'h0)) & wmask();
    endtask

    task automatic load_data(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) dat[i] = v[n-1-i];
        dat_n = n;
    endtask

    // Expected sending stream (R6, R8)
    task automatic model_send();
        logic w, b;
        m7 = '1; m9 = '1; mc = cfg_crc_seed & wmask();
        exp_n = 0;
        for (int i = 0; i < dat_n; i++) begin
            m_white(w);
            exp_b[exp_n] = dat[i] ^ w; exp_p[exp_n] = 1'b0; raw[exp_n] = dat[i];
            m_crc(dat[i]);
            exp_n++;
        end
        for (int k = wid() - 1; k >= 0; k--) begin
            b = mc[k];
            m_white(w);
            exp_b[exp_n] = cfg_copro ? b : (b ^ w); exp_p[exp_n] = 1'b1; raw[exp_n] = b;
            exp_n++;
        end
    endtask

    task automatic drive_frame();
        cap_n = 0;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        chk("R7 crc_error cleared by frame_start", 32'(crc_error), 32'd0);
        for (int i = 0; i < drv_n; i++) begin
            in_valid = 1'b1; in_bit = drv[i];
            @(negedge clk);
            if (i % 5 == 2) begin
                in_valid = 1'b0; in_bit = ~in_bit;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic compare(string tag);
        chk({tag, " bit count"}, 32'(cap_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk({tag, " bit"}, 32'(cap_b[i]), 32'(exp_b[i]));
            chk({tag, " phase"}, 32'(cap_p[i]), 32'(exp_p[i]));
        end
    endtask

    task automatic set_cfg(bit tx, bit cop, bit e7, bit e9, logic [1:0] len,
                           logic [31:0] poly, logic [31:0] seed);
        cfg_tx = tx; cfg_copro = cop; cfg_pn7_en = e7; cfg_pn9_en = e9;
        cfg_crc_len = len; cfg_crc_poly = poly; cfg_crc_seed = seed;
    endtask

    task automatic run_send(string tag);
        model_send();
        for (int i = 0; i < dat_n; i++) drv[i] = dat[i];
        drv_n = dat_n;
        drive_frame();
        compare(tag);
    endtask

    // R1
    task automatic t_reset();
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 out_crc_phase", 32'(out_crc_phase), 0);
        chk("R1 crc_error", 32'(crc_error), 0);
    endtask

    // R9
    task automatic t_idle_ignore();
        cap_n = 0;
        repeat (3) begin
            @(negedge clk); in_valid = 1'b1; in_bit = 1'b1;
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 no output in idle", 32'(cap_n), 0);
    endtask

    // R7: receive a sent frame, optionally with one bit flipped
    task automatic t_receive(string tag, int flip, logic exp_err);
        set_cfg(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 32'h1021, 32'hFFFF);
        load_data(64'h0000_A5C3_0F96_3C5A, 48);
        model_send();
        for (int i = 0; i < exp_n; i++) drv[i] = exp_b[i];
        drv_n = exp_n;
        for (int i = 0; i < exp_n; i++) begin
            exp_b[i] = raw[i]; exp_p[i] = 1'b0;
        end
        if (flip >= 0) begin
            drv[flip]   = ~drv[flip];
            exp_b[flip] = ~exp_b[flip];
        end
        cfg_tx = 1'b0;
        drive_frame();
        compare(tag);
        chk({tag, " crc_error"}, 32'(crc_error), 32'(exp_err));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignore();

        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 32'h1021, 32'hFFFF);
        load_data(64'h3132_3334_3536, 48);
        run_send("R2 R6 plain send crc16");

        set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 32'h07, 32'h00);
        load_data(64'h0, 40);
        run_send("R3 pn7 zeros crc8");

        set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 32'h864CFB, 32'hB704CE);
        load_data(64'hDEAD_BEEF_0123, 48);
        run_send("R4 R10 pn9 crc24");

        set_cfg(1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 32'h04C1_1DB7, 32'hFFFF_FFFF);
        load_data(64'hFEDC_BA98_7654_3210, 64);
        run_send("R5 R10 both crc32");

        t_receive("R7 receive clean", -1, 1'b0);
        t_receive("R7 receive corrupt", 30, 1'b1);

        set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 32'h8005, 32'h0);
        load_data(64'h55AA_F00F, 32);
        run_send("R8 helper mode");

        t_idle_ignore();
        report();
    end

endmodule